// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns one parallel character into an asynchronous serial frame on a single output line. Software or a neighbouring block writes a character into a holding register. When the shifter is idle, the character moves into it and is sent as a frame: a low start bit, five to eight data bits with the least significant bit first, an optional parity bit, and a high stop period.

The frame shape comes from a packed control byte:

- bits [1:0] select the character length.
- bit 2 selects a long stop period.
- bit 3 turns parity on.
- bit 4 chooses even parity.
- bit 5 chooses stick parity.
- bit 6 forces the line low (break).

Bit timing is set by an enable pulse that runs at sixteen times the bit rate. The transmitter reports two things separately: that the holding register can accept a new character, and that the whole transmitter has gone quiet.

The control is a five-state machine: IDLE, START, DATA, PARITY and STOP. Its transitions are:

- IDLE→START when the holding register is occupied. This is the load; the holding register is emptied in the same clock.
- START→DATA after one bit time.
- DATA→DATA after each bit time while data bits remain.
- DATA→PARITY after the last data bit when parity is on.
- DATA→STOP after the last data bit when parity is off.
- PARITY→STOP after one bit time.
- STOP→IDLE when the stop period ends.

Top module: `serial_tx_core`

## Requirements
- R1: Control bits [1:0] select the character length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. A frame is one start bit at 0, then the data bits, least significant first.
- R2: Every start, data and parity bit lasts exactly 16 pulses of `tick_en`. Clock cycles without `tick_en` do not advance the frame.
- R3: With control bit 2 at 0, the stop period is one bit time (16 pulses) at 1.
- R4: With control bit 2 at 1, the stop period is 24 pulses for a 5-bit length and 32 pulses for 6, 7 or 8 bits.
- R5: With control bit 3 at 1, a parity bit follows the data. If control bit 4 is 1, data plus parity hold an even number of ones; if it is 0, an odd number.
- R6: With control bits 3 and 5 both at 1, the parity bit is the inverse of control bit 4.
- R7: While control bit 6 is 1, `txd` is 0 at once, whatever the state. The frame in progress keeps its timing, so `tx_empty` rises at the same point it would without the break. When bit 6 returns to 0 on an idle transmitter, `txd` is 1.
- R8: A write makes `hold_empty` 0 on the next clock. If the shifter is idle, the character is loaded on the clock after that: `hold_empty` returns to 1 and `txd` goes to the start level.
- R9: `tx_empty` is 1 only when the holding register is empty and no frame is in progress. An idle line without break is at 1.
- R10: Control bits [5:0] are captured at load, so changing them during a frame does not change that frame. Control bit 7 has no effect.
- R11: After reset, `txd`, `hold_empty` and `tx_empty` are all 1.
- R12: A character written during a frame waits in the holding register with `hold_empty` at 0. It is loaded on the first clock after the stop period ends, so the line gets no extra idle bit time between the two frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Enable pulse at sixteen times the bit rate |
| line_ctrl | input | 8 | Packed frame format and break control |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Character to send |
| txd | output | 1 | Serial line, idle high |
| hold_empty | output | 1 | Holding register can take a character |
| tx_empty | output | 1 | Holding register and shifter both empty |

## Verification
The bench builds the block with its defaults: 8-bit data and 16 ticks per bit. At that size every one of the 64 format codes in control bits [5:0] can be swept with three data patterns each, and the expected line level is computed arithmetically for every bit of every frame. The enable pulse skips every third clock, which shows that bit timing counts enable pulses rather than clocks. Separate runs cover break frames, a character queued behind a running frame while the format changes mid-frame, and the 24- and 32-pulse stop boundaries.

// File: rtl/stx_pkg.sv
package stx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_START  = 3'd1,
        ST_DATA   = 3'd2,
        ST_PARITY = 3'd3,
        ST_STOP   = 3'd4
    } stx_state_e;

    typedef struct packed {
        logic       par_stick;
        logic       par_even;
        logic       par_en;
        logic       stop_long;
        logic [1:0] len_sel;
    } stx_fmt_t;

    // Unpack the six format bits of the control byte.
    function automatic stx_fmt_t decode_fmt(input logic [5:0] raw);
        stx_fmt_t f;
        f.len_sel   = raw[1:0];
        f.stop_long = raw[2];
        f.par_en    = raw[3];
        f.par_even  = raw[4];
        f.par_stick = raw[5];
        return f;
    endfunction

endpackage

// File: rtl/stx_holding.sv
module stx_holding #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            data <= '0;
        end else if (wr_en) begin
            data <= wr_data;
            full <= 1'b1;
        end else if (take) begin
            full <= 1'b0;
        end
    end

    AST_TAKE_NEEDS_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> full); // R8
    AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> full); // R12

endmodule

// File: rtl/stx_parity.sv
module stx_parity #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] data,
    input  stx_pkg::stx_fmt_t fmt,
    output logic              par_bit
);

    localparam int MIN_LEN = DATA_W - 3;

    logic ones_odd;

    always_comb begin
        ones_odd = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < MIN_LEN + int'(fmt.len_sel)) begin
                ones_odd = ones_odd ^ data[i];
            end
        end
        if (fmt.par_stick) begin
            par_bit = ~fmt.par_even;
        end else if (fmt.par_even) begin
            par_bit = ones_odd;
        end else begin
            par_bit = ~ones_odd;
        end
    end

endmodule

// File: rtl/stx_bit_timer.sv
module stx_bit_timer #(
    parameter int TICK_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick_en,
    input  logic [TICK_W-1:0] limit,
    output logic              last
);

    logic [TICK_W-1:0] cnt_q;

    assign last = run && tick_en && (cnt_q == limit - TICK_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (tick_en) begin
            cnt_q <= last ? '0 : cnt_q + TICK_W'(1);
        end
    end

    AST_COUNT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q < limit)); // R2

endmodule

// File: rtl/stx_fsm.sv
module stx_fsm #(
    parameter int DATA_W = 8,
    parameter int OSR    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  stx_pkg::stx_fmt_t fmt_in,
    input  logic              hold_full,
    input  logic [DATA_W-1:0] hold_data,
    input  logic              par_in,
    output logic              take,
    output logic              busy,
    output logic              frame_bit
);
    import stx_pkg::*;

    localparam int TICK_W    = $clog2(2 * OSR + 1);
    localparam int IDX_W     = $clog2(DATA_W);
    localparam int STOP_ONE  = OSR;
    localparam int STOP_HALF = OSR + OSR / 2;
    localparam int STOP_TWO  = 2 * OSR;

    stx_state_e        state_q, state_d;
    stx_fmt_t          fmt_q;
    logic [DATA_W-1:0] shift_q;
    logic              par_q;
    logic [IDX_W-1:0]  idx_q;
    logic [IDX_W-1:0]  len_m1;
    logic [TICK_W-1:0] limit;
    logic              bit_last;

    assign len_m1 = IDX_W'(DATA_W - 4) + IDX_W'(fmt_q.len_sel);

    always_comb begin
        if (state_q == ST_STOP) begin
            if (!fmt_q.stop_long)          limit = TICK_W'(STOP_ONE);
            else if (fmt_q.len_sel == 2'd0) limit = TICK_W'(STOP_HALF);
            else                            limit = TICK_W'(STOP_TWO);
        end else begin
            limit = TICK_W'(OSR);
        end
    end

    stx_bit_timer #(.TICK_W(TICK_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (busy),
        .tick_en (tick_en),
        .limit   (limit),
        .last    (bit_last)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (hold_full) state_d = ST_START;
            ST_START:  if (bit_last)  state_d = ST_DATA;
            ST_DATA:   if (bit_last && idx_q == len_m1)
                           state_d = fmt_q.par_en ? ST_PARITY : ST_STOP;
            ST_PARITY: if (bit_last)  state_d = ST_STOP;
            ST_STOP:   if (bit_last)  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Frame datapath: format, parity and shifter captured at load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fmt_q   <= '0;
            shift_q <= '0;
            par_q   <= 1'b0;
            idx_q   <= '0;
        end else if (take) begin
            fmt_q   <= fmt_in;
            shift_q <= hold_data;
            par_q   <= par_in;
            idx_q   <= '0;
        end else if (state_q == ST_DATA && bit_last) begin
            shift_q <= shift_q >> 1;
            idx_q   <= idx_q + IDX_W'(1);
        end
    end

    // Outputs
    always_comb begin
        take      = (state_q == ST_IDLE) && hold_full;
        busy      = (state_q != ST_IDLE);
        frame_bit = 1'b1;
        unique case (state_q)
            ST_IDLE:   frame_bit = 1'b1;
            ST_START:  frame_bit = 1'b0;
            ST_DATA:   frame_bit = shift_q[0];
            ST_PARITY: frame_bit = par_q;
            ST_STOP:   frame_bit = 1'b1;
            default:   frame_bit = 1'b1;
        endcase
    end

    AST_LOAD_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (state_q == ST_START)); // R8
    AST_PARITY_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PARITY) |-> fmt_q.par_en); // R5
    AST_INDEX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA) |-> (idx_q <= len_m1)); // R1
    AST_FORMAT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !take && $past(busy)) |-> $stable(fmt_q)); // R10

endmodule

// File: rtl/serial_tx_core.sv
module serial_tx_core #(
    parameter int DATA_W = 8,
    parameter int OSR    = 16,
    parameter int CTRL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [CTRL_W-1:0] line_ctrl,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              txd,
    output logic              hold_empty,
    output logic              tx_empty
);
    import stx_pkg::*;

    localparam int BRK_BIT = 6;

    stx_fmt_t          fmt_live;
    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              take;
    logic              busy;
    logic              frame_bit;
    logic              par_bit;

    assign fmt_live = decode_fmt(line_ctrl[5:0]);

    stx_holding #(.DATA_W(DATA_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .take    (take),
        .full    (hold_full),
        .data    (hold_data)
    );

    stx_parity #(.DATA_W(DATA_W)) u_par (
        .data    (hold_data),
        .fmt     (fmt_live),
        .par_bit (par_bit)
    );

    stx_fsm #(.DATA_W(DATA_W), .OSR(OSR)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .fmt_in    (fmt_live),
        .hold_full (hold_full),
        .hold_data (hold_data),
        .par_in    (par_bit),
        .take      (take),
        .busy      (busy),
        .frame_bit (frame_bit)
    );

    assign txd        = line_ctrl[BRK_BIT] ? 1'b0 : frame_bit;
    assign hold_empty = ~hold_full;
    assign tx_empty   = ~hold_full & ~busy;

    AST_TEMT_NEEDS_THRE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> hold_empty); // R9
    AST_IDLE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_empty && !line_ctrl[BRK_BIT]) |-> txd); // R9

endmodule

// File: tb/serial_tx_core_test.sv
`timescale 1ns/1ps
module serial_tx_core_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic [7:0] line_ctrl = 8'h00;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       txd, hold_empty, tx_empty;

    int  n_cmp = 0;
    int  n_bad = 0;
    int  phase = 0;
    bit  done = 0;

    always #2.5 clk = ~clk;

    serial_tx_core uut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .line_ctrl(line_ctrl),
        .wr_en(wr_en), .wr_data(wr_data), .txd(txd),
        .hold_empty(hold_empty), .tx_empty(tx_empty)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int len_of(input logic [5:0] f);
        return 5 + int'(f[1:0]);
    endfunction

    function automatic int stop_of(input logic [5:0] f);
        if (!f[2]) return 16;
        return (f[1:0] == 2'd0) ? 24 : 32;
    endfunction

    function automatic int total_of(input logic [5:0] f);
        return 16 * (1 + len_of(f) + int'(f[3])) + stop_of(f);
    endfunction

    function automatic logic exp_bit(input logic [5:0] f, input logic [7:0] d, input int idx);
        int  n = len_of(f);
        logic ones = 1'b0;
        for (int i = 0; i < n; i++) ones = ones ^ d[i];
        if (idx == 0) return 1'b0;
        if (idx <= n) return d[idx-1];
        if (f[3] && idx == n + 1) begin
            if (f[5]) return ~f[4];
            return f[4] ? ones : ~ones;
        end
        return 1'b1;
    endfunction

    // Called at the falling edge just after a load; follows the frame tick by tick.
    task automatic body(input logic [5:0] f, input logic [7:0] d, input bit brk,
                        input bit queue, input logic [7:0] nd, input logic [7:0] nctrl);
        int  c = 0;
        int  tot = total_of(f);
        int  wstate = 0;
        logic e;
        while (c < tot) begin
            if (c % 16 == 8) begin
                e = brk ? 1'b0 : exp_bit(f, d, c / 16);
                // R1 R3 R4 R5 R6 R7 bit levels
                chk(txd === e, (c/16 == 0) ? "R1 start" : (c/16 <= len_of(f)) ? "R1 data" :
                    (f[3] && c/16 == len_of(f)+1) ? (f[5] ? "R6 stick" : "R5 parity") :
                    (brk ? "R7 break" : "R3 stop"), int'(txd), int'(e));
            end
            if (c == tot - 1) begin
                chk(txd === (brk ? 1'b0 : 1'b1), "R4 stop end level", int'(txd), brk ? 0 : 1);
                chk(tx_empty === 1'b0, "R2 busy until stop end", int'(tx_empty), 0);
            end
            if (wstate == 1) begin
                wr_en = 1'b0;
                chk(hold_empty === 1'b0, "R12 queued char held", int'(hold_empty), 0);
                wstate = 2;
            end
            if (queue && wstate == 0 && c == 20) begin
                wr_en = 1'b1; wr_data = nd;
                line_ctrl = nctrl;      // R10 mid-frame format change
                wstate = 1;
            end
            tick_en = (phase % 3) != 2;
            phase++;
            if (tick_en) c++;
            @(negedge clk);
        end
        chk(tx_empty === !queue, "R9 tx_empty at frame end", int'(tx_empty), int'(!queue));
        chk(txd === (brk ? 1'b0 : 1'b1), "R9 line after frame", int'(txd), brk ? 0 : 1);
        if (queue) chk(hold_empty === 1'b0, "R12 still held", int'(hold_empty), 0);
    endtask

    task automatic launch(input logic [7:0] ctrl, input logic [7:0] d);
        line_ctrl = ctrl;
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        chk(hold_empty === 1'b0, "R8 write clears hold_empty", int'(hold_empty), 0);
        chk(tx_empty === 1'b0, "R9 tx_empty low with char", int'(tx_empty), 0);
        @(negedge clk);
        chk(hold_empty === 1'b1, "R8 load frees holding", int'(hold_empty), 1);
        chk(txd === 1'b0, "R8 start after load", int'(txd), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(txd === 1'b1, "R11 txd", int'(txd), 1);
        chk(hold_empty === 1'b1, "R11 hold_empty", int'(hold_empty), 1);
        chk(tx_empty === 1'b1, "R11 tx_empty", int'(tx_empty), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(txd === 1'b1 && tx_empty === 1'b1, "R11 idle after reset", int'(txd), 1);

        // Sweep every format code with three data patterns (bit 7 set on one: R10)
        for (int f = 0; f < 64; f++) begin
            for (int k = 0; k < 3; k++) begin
                d = (k == 0) ? (8'hA5 ^ 8'(f * 3)) : (k == 1) ? 8'(f * 37 + 1) : ~8'(f);
                launch({(k == 2), 1'b0, 6'(f)}, d);
                body(6'(f), d, 1'b0, 1'b0, 8'h00, 8'h00);
            end
        end

        // Break frames: line forced low, timing unchanged (R7)
        for (int f = 0; f < 64; f += 9) begin
            launch({2'b01, 6'(f)}, 8'h3C);
            body(6'(f), 8'h3C, 1'b1, 1'b0, 8'h00, 8'h00);
            line_ctrl[6] = 1'b0;
            #1;
            chk(txd === 1'b1, "R7 release break", int'(txd), 1);
            @(negedge clk);
        end

        // Queued character with mid-frame format change (R10, R12)
        launch(8'h1B, 8'h96);
        body(6'h1B, 8'h96, 1'b0, 1'b1, 8'h4D, 8'h20);
        @(negedge clk);
        chk(hold_empty === 1'b1, "R12 queued char loaded", int'(hold_empty), 1);
        chk(txd === 1'b0, "R12 back-to-back start", int'(txd), 0);
        body(6'h20, 8'h4D, 1'b0, 1'b0, 8'h00, 8'h00);

        launch(8'h04, 8'h11);
        body(6'h04, 8'h11, 1'b0, 1'b1, 8'hE7, 8'h3F);
        @(negedge clk);
        chk(hold_empty === 1'b1, "R12 second queue load", int'(hold_empty), 1);
        body(6'h3F, 8'hE7, 1'b0, 1'b0, 8'h00, 8'h00);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule